// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Control Register Window

This block is the host-visible register file for two IDE bus-master DMA channels. It occupies a 16-byte I/O window: the low 8 bytes belong to channel 0 and the high 8 bytes to channel 1. Within each half, the lower four bytes are a byte-only command/status port and the upper four bytes hold a 32-bit descriptor-table pointer. The host reaches the window through a plain register bus with an address, an access size, read and write strobes and 32-bit data. Write data is aligned to the addressed byte, so byte lane 0 of `bus_wdata` lands at the addressed offset.

Each channel drives a start control and a transfer direction control, plus its table pointer, toward a separate DMA engine. The engine reports back through three signals per channel: a busy level, an error pulse and a drive-interrupt pulse. The status byte mixes three kinds of bits in one register. Two bits are software-writable flags, one bit is owned by hardware, and two event bits are cleared by writing a one to them.

Top module: `bmdma_regwin`

## Requirements
- R1: Channel n owns offsets 8n..8n+7. A byte read returns the command byte at channel offset 0, the status byte at offset 2 and 0xFF at offsets 1 and 3. The pointer occupies offsets 4..7, least significant byte first. `bus_rdata` is zero when `bus_rd` is low.
- R2: Access size is encoded on `bus_size` as 0 for byte, 1 for 16-bit and 2 for 32-bit. A read of the command/status port whose size is not byte returns all ones across the access width: 0x0000FFFF for 16-bit and 0xFFFFFFFF for 32-bit.
- R3: A write to the command/status port whose size is not byte changes neither the command byte nor the software-writable status bits.
- R4: A byte write to status offset 2 loads status bits 6 and 5 from the written value. Bit 0 keeps its hardware-owned value whatever is written.
- R5: In a status byte write, bits 2 and 1 clear where the written bit is 1 and hold where it is 0. Status bits 7, 4 and 3 always read as zero.
- R6: In the command byte, bit 0 is start, driving `xfer_start`. Bit 3 is direction (1 = device to memory), driving `xfer_to_mem`. A write to bit 3 is ignored while bit 0 is already 1. All other command bits read as zero.
- R7: Status bit 0 equals the channel's `eng_busy` sampled on the previous clock edge. An `eng_err` pulse sets status bit 1 and an `eng_irq` pulse sets status bit 2. When a hardware set and a software clear of the same bit fall in one cycle, the bit ends up set.
- R8: The pointer accepts byte, 16-bit and 32-bit writes on the byte lanes from the addressed offset upward, with lanes past offset 7 dropped. Reads return the pointer shifted down by the offset and masked to the access width. Pointer bits 1:0 are always zero.
- R9: Reset clears the command bytes, the pointers and status bits 0, 1 and 2 of both channels. Status bits 6:5 come out of reset at the parameter `CAP_RST`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 4 | Byte offset into the window |
| bus_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wr | input | 1 | Write strobe; takes effect at the clock edge |
| bus_wdata | input | 32 | Write data, byte 0 at the addressed offset |
| bus_rdata | output | 32 | Read data, byte 0 from the addressed offset |
| eng_busy | input | 2 | Per-channel transfer-running level |
| eng_err | input | 2 | Per-channel error event pulse |
| eng_irq | input | 2 | Per-channel drive-interrupt event pulse |
| xfer_start | output | 2 | Per-channel start control (command bit 0) |
| xfer_to_mem | output | 2 | Per-channel direction control (command bit 3) |
| table_ptr | output | 64 | Descriptor-table pointers, channel 1 in bits 63:32 |

## Verification
The bench drives 16-bit and 32-bit reads and writes at the command/status port. A design that decodes only the low address bits would return real register contents for those reads, or accept those writes. It also writes status bytes with all bits set. This exposes a design that lets software force the busy bit, keeps the unused bits, or writes the event bits directly instead of clearing them on ones.

Directed cases follow. One rewrites the direction bit while start is set. One makes an error pulse coincide with a clearing write, where a wrong priority leaves the bit clear. Another writes wide to the pointer at unaligned offsets, which catches lane shifting that runs off the end or leaves bits 1:0 nonzero.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int unsigned CH_SPAN = 8;

  // data mask for an access of the given size (reserved treated as 32-bit)
  function automatic logic [31:0] width_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: width_mask = 32'h0000_00FF;
      SZ_HALF: width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  // byte enables of an access of the given size at lane 0
  function automatic logic [3:0] lane_base(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_base = 4'b0001;
      SZ_HALF: lane_base = 4'b0011;
      default: lane_base = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/bmdma_chan.sv
module bmdma_chan #(
  parameter logic [1:0] CAP_RST = 2'b00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic        sts_we,
  input  logic [3:0]  ptr_be,
  input  logic [7:0]  wbyte,
  input  logic [31:0] ptr_wdata,
  input  logic        eng_busy,
  input  logic        eng_err,
  input  logic        eng_irq,
  output logic [7:0]  cmd_q,
  output logic [7:0]  sts_q,
  output logic [31:0] ptr_q
);

  logic       start_q, start_d;
  logic       dir_q, dir_d;
  logic       act_q, act_d;
  logic       err_q, err_d;
  logic       irq_q, irq_d;
  logic [1:0] cap_q, cap_d;
  logic       cmd_en, cap_en, flag_en;
  logic       unused_wbits;

  assign unused_wbits = ^{wbyte[7], wbyte[4], wbyte[2:1]} ^ ^{wbyte[6:5]};

  // next-state logic
  always_comb begin
    start_d = start_q;
    dir_d   = dir_q;
    if (cmd_we) begin
      start_d = wbyte[0];
      if (!start_q) dir_d = wbyte[3];
    end
    cap_d = cap_q;
    err_d = err_q;
    irq_d = irq_q;
    if (sts_we) begin
      cap_d = wbyte[6:5];
      if (wbyte[1]) err_d = 1'b0;
      if (wbyte[2]) irq_d = 1'b0;
    end
    if (eng_err) err_d = 1'b1;
    if (eng_irq) irq_d = 1'b1;
    act_d = eng_busy;
  end

  assign cmd_en  = cmd_we;
  assign cap_en  = sts_we;
  assign flag_en = sts_we | eng_err | eng_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
    end else if (cmd_en) begin
      start_q <= start_d;
      dir_q   <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= CAP_RST;
    else if (cap_en) cap_q <= cap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (flag_en) begin
      err_q <= err_d;
      irq_q <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  // descriptor pointer, one register per byte lane; bits 1:0 not stored
  genvar b;
  generate
    for (b = 0; b < 4; b++) begin : g_lane
      if (b == 0) begin : g_low
        logic [7:2] lo_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)         lo_q <= '0;
          else if (ptr_be[0]) lo_q <= ptr_wdata[7:2];
        end
        assign ptr_q[7:0] = {lo_q, 2'b00};
      end else begin : g_full
        logic [7:0] by_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)         by_q <= '0;
          else if (ptr_be[b]) by_q <= ptr_wdata[b*8 +: 8];
        end
        assign ptr_q[b*8 +: 8] = by_q;
      end
    end
  endgenerate

  logic unused_plow;
  assign unused_plow = ^ptr_wdata[1:0];

  assign cmd_q = {4'b0000, dir_q, 2'b00, start_q};
  assign sts_q = {1'b0, cap_q, 2'b00, irq_q, err_q, act_q};

  // assertions
  p_busy_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (sts_q[0] == $past(eng_busy)));
  p_err_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(eng_err)) |-> sts_q[1]);
  p_irq_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(eng_irq)) |-> sts_q[2]);
  p_dir_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(start_q)) |-> (dir_q == $past(dir_q)));
  p_zero_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[7] == 1'b0) && (sts_q[4:3] == 2'b00) && (cmd_q[7:4] == 4'h0) && (cmd_q[2:1] == 2'b00));
  p_ptr_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q[1:0] == 2'b00);

endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
  import bmdma_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned AW  = $clog2(NUM_CH) + 3,
  localparam int unsigned CHW = AW - 3
) (
  input  logic [AW-1:0]            addr,
  input  logic [1:0]               size,
  input  logic                     rd,
  input  logic [NUM_CH-1:0][7:0]   cmd_all,
  input  logic [NUM_CH-1:0][7:0]   sts_all,
  input  logic [NUM_CH-1:0][31:0]  ptr_all,
  output logic [31:0]              rdata
);

  logic [CHW-1:0] ch;
  logic [1:0]     lane;

  assign ch   = addr[AW-1:3];
  assign lane = addr[1:0];

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (!addr[2]) begin
        if (size != SZ_BYTE) begin
          rdata = width_mask(size);
        end else begin
          case (lane)
            2'd0:    rdata = {24'h0, cmd_all[ch]};
            2'd2:    rdata = {24'h0, sts_all[ch]};
            default: rdata = 32'h0000_00FF;
          endcase
        end
      end else begin
        rdata = (ptr_all[ch] >> {lane, 3'b000}) & width_mask(size);
      end
    end
  end

endmodule

// File: rtl/bmdma_regwin.sv
module bmdma_regwin
  import bmdma_pkg::*;
#(
  parameter int unsigned NUM_CH  = 2,
  parameter logic [1:0]  CAP_RST = 2'b00,
  localparam int unsigned AW  = $clog2(NUM_CH) + 3,
  localparam int unsigned CHW = AW - 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        bus_addr,
  input  logic [1:0]           bus_size,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_CH-1:0]    eng_busy,
  input  logic [NUM_CH-1:0]    eng_err,
  input  logic [NUM_CH-1:0]    eng_irq,
  output logic [NUM_CH-1:0]    xfer_start,
  output logic [NUM_CH-1:0]    xfer_to_mem,
  output logic [NUM_CH*32-1:0] table_ptr
);

  logic [NUM_CH-1:0][7:0]  cmd_all;
  logic [NUM_CH-1:0][7:0]  sts_all;
  logic [NUM_CH-1:0][31:0] ptr_all;

  logic [CHW-1:0] ch_sel;
  logic [1:0]     lane;
  logic           byte_acc;
  logic           port_wr_cmd, port_wr_sts, ptr_wr;
  logic [6:0]     be_wide;
  logic [3:0]     ptr_be;
  logic [31:0]    wdata_sh;

  assign ch_sel   = bus_addr[AW-1:3];
  assign lane     = bus_addr[1:0];
  assign byte_acc = (bus_size == SZ_BYTE);

  // command/status port accepts byte writes only
  assign port_wr_cmd = bus_wr && !bus_addr[2] && byte_acc && (lane == 2'd0);
  assign port_wr_sts = bus_wr && !bus_addr[2] && byte_acc && (lane == 2'd2);
  assign ptr_wr      = bus_wr && bus_addr[2];

  assign be_wide  = {3'b000, lane_base(bus_size)} << lane;
  assign ptr_be   = ptr_wr ? be_wide[3:0] : 4'b0000;
  assign wdata_sh = bus_wdata << {lane, 3'b000};

  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      assign hit = (ch_sel == CHW'(i));

      bmdma_chan #(.CAP_RST(CAP_RST)) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (port_wr_cmd && hit),
        .sts_we    (port_wr_sts && hit),
        .ptr_be    (hit ? ptr_be : 4'b0000),
        .wbyte     (bus_wdata[7:0]),
        .ptr_wdata (wdata_sh),
        .eng_busy  (eng_busy[i]),
        .eng_err   (eng_err[i]),
        .eng_irq   (eng_irq[i]),
        .cmd_q     (cmd_all[i]),
        .sts_q     (sts_all[i]),
        .ptr_q     (ptr_all[i])
      );

      assign xfer_start[i]           = cmd_all[i][0];
      assign xfer_to_mem[i]          = cmd_all[i][3];
      assign table_ptr[i*32 +: 32]   = ptr_all[i];
    end
  endgenerate

  bmdma_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
    .addr    (bus_addr),
    .size    (bus_size),
    .rd      (bus_rd),
    .cmd_all (cmd_all),
    .sts_all (sts_all),
    .ptr_all (ptr_all),
    .rdata   (bus_rdata)
  );

  // assertions
  p_half_read_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr[2] && bus_size == SZ_HALF) |-> (bus_rdata == 32'h0000_FFFF));
  p_word_read_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr[2] && bus_size == SZ_WORD) |-> (bus_rdata == 32'hFFFF_FFFF));
  p_wide_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bus_wr && !bus_addr[2] && bus_size != SZ_BYTE))
      |-> ($stable(cmd_all) && $stable(xfer_to_mem)));
  p_idle_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 32'h0));

endmodule

// File: tb/bmdma_regwin_bench.sv
module bmdma_regwin_bench;

  localparam logic [1:0] CAP = 2'b01;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic [1:0]  bus_size;
  logic        bus_rd, bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  eng_busy, eng_err, eng_irq;
  logic [1:0]  xfer_start, xfer_to_mem;
  logic [63:0] table_ptr;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]  m_cmd [2];
  logic [7:0]  m_sts [2];
  logic [31:0] m_ptr [2];

  always #10 clk = ~clk;

  bmdma_regwin #(.NUM_CH(2), .CAP_RST(CAP)) u_bmdma_regwin (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .eng_err(eng_err), .eng_irq(eng_irq),
    .xfer_start(xfer_start), .xfer_to_mem(xfer_to_mem), .table_ptr(table_ptr)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a, input logic [1:0] sz);
    int c = a[3];
    if (!a[2]) begin
      if (sz != 2'd0) return wmask(sz);
      if (a[1:0] == 2'd0) return {24'h0, m_cmd[c]};
      if (a[1:0] == 2'd2) return {24'h0, m_sts[c]};
      return 32'hFF;
    end
    return (m_ptr[c] >> (8 * a[1:0])) & wmask(sz);
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_cmd[c] = 8'h00;
      m_sts[c] = {1'b0, CAP, 5'b00000};
      m_ptr[c] = 32'h0;
    end
  endtask

  task automatic model_update(input logic wr, input logic [3:0] a, input logic [1:0] sz,
                              input logic [31:0] wd, input logic [1:0] busy,
                              input logic [1:0] err, input logic [1:0] irq);
    for (int c = 0; c < 2; c++) begin
      logic hit = (a[3] == c[0]);
      logic [7:0] w = wd[7:0];
      if (wr && hit && !a[2] && sz == 2'd0 && a[1:0] == 2'd0) begin
        logic d = m_cmd[c][0] ? m_cmd[c][3] : w[3];
        m_cmd[c] = {4'b0, d, 2'b00, w[0]};
      end
      if (wr && hit && !a[2] && sz == 2'd0 && a[1:0] == 2'd2)
        m_sts[c] = (w & 8'h60) | (m_sts[c] & 8'h01) | (m_sts[c] & ~w & 8'h06);
      m_sts[c][0] = busy[c];
      if (err[c]) m_sts[c][1] = 1'b1;
      if (irq[c]) m_sts[c][2] = 1'b1;
      if (wr && hit && a[2]) begin
        int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        for (int k = 0; k < nb; k++)
          if (a[1:0] + k < 4) m_ptr[c][8*(a[1:0]+k) +: 8] = wd[8*k +: 8];
        m_ptr[c][1:0] = 2'b00;
      end
    end
  endtask

  // one bus cycle: drive at negedge, check, then advance the model
  task automatic step(input logic rd, input logic wr, input logic [3:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, input logic [1:0] busy, input logic [1:0] err,
                      input logic [1:0] irq, input string req);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    eng_busy = busy; eng_err = err; eng_irq = irq;
    #1;
    if (rd) check(req, $sformatf("read a=%0d sz=%0d", a, sz), {32'h0, bus_rdata}, {32'h0, exp_read(a, sz)});
    else    check("R1", "idle rdata", {32'h0, bus_rdata}, 64'h0);
    check("R6", "start/dir outs", {60'h0, xfer_to_mem, xfer_start},
          {60'h0, m_cmd[1][3], m_cmd[0][3], m_cmd[1][0], m_cmd[0][0]});
    check("R8", "table_ptr", table_ptr, {m_ptr[1], m_ptr[0]});
    model_update(wr, a, sz, wd, busy, err, irq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_size = 0; bus_wdata = 0;
    eng_busy = 0; eng_err = 0; eng_irq = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9 reset state, R1 map
    for (int c = 0; c < 2; c++) begin
      step(1, 0, 4'(c*8),     2'd0, 0, 0, 0, 0, "R9");
      step(1, 0, 4'(c*8 + 2), 2'd0, 0, 0, 0, 0, "R9");
      step(1, 0, 4'(c*8 + 4), 2'd2, 0, 0, 0, 0, "R9");
      step(1, 0, 4'(c*8 + 1), 2'd0, 0, 0, 0, 0, "R1");
      step(1, 0, 4'(c*8 + 3), 2'd0, 0, 0, 0, 0, "R1");
    end
    // R2 wide reads of the port
    step(1, 0, 4'd0, 2'd1, 0, 0, 0, 0, "R2");
    step(1, 0, 4'd10, 2'd2, 0, 0, 0, 0, "R2");
    // R3 wide writes ignored
    step(0, 1, 4'd2, 2'd1, 32'hFFFF_FFFF, 0, 0, 0, "R3");
    step(0, 1, 4'd8, 2'd2, 32'hFFFF_FFFF, 0, 0, 0, "R3");
    step(1, 0, 4'd2, 2'd0, 0, 0, 0, 0, "R3");
    step(1, 0, 4'd8, 2'd0, 0, 0, 0, 0, "R3");
    // R4/R5 status write of all ones, busy held
    step(0, 0, 4'd0, 2'd0, 0, 2'b01, 2'b01, 2'b01, "R7");
    step(0, 1, 4'd2, 2'd0, 32'hFF, 2'b01, 0, 0, "R5");
    step(1, 0, 4'd2, 2'd0, 0, 2'b01, 0, 0, "R4");
    // R7 hardware set wins over software clear
    step(0, 1, 4'd10, 2'd0, 32'h06, 0, 2'b10, 2'b10, "R7");
    step(1, 0, 4'd10, 2'd0, 0, 0, 0, 0, "R7");
    // R6 direction frozen while started
    step(0, 1, 4'd0, 2'd0, 32'h09, 0, 0, 0, "R6");
    step(0, 1, 4'd0, 2'd0, 32'hF1, 0, 0, 0, "R6");
    step(1, 0, 4'd0, 2'd0, 0, 0, 0, 0, "R6");
    step(0, 1, 4'd0, 2'd0, 32'h00, 0, 0, 0, "R6");
    step(1, 0, 4'd0, 2'd0, 0, 0, 0, 0, "R6");
    // R8 pointer lanes
    step(0, 1, 4'd12, 2'd2, 32'hDEAD_BEEF, 0, 0, 0, "R8");
    step(0, 1, 4'd7, 2'd2, 32'h1234_5678, 0, 0, 0, "R8");
    step(0, 1, 4'd5, 2'd1, 32'hA5C3, 0, 0, 0, "R8");
    step(1, 0, 4'd4, 2'd2, 0, 0, 0, 0, "R8");
    step(1, 0, 4'd13, 2'd1, 0, 0, 0, 0, "R8");
    step(1, 0, 4'd15, 2'd2, 0, 0, 0, 0, "R8");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] busy = eng_busy;
      if ($urandom_range(0, 7) == 0) busy = 2'($urandom);
      step(1'($urandom), ($urandom_range(0, 2) == 0), 4'($urandom), 2'($urandom_range(0, 2)),
           $urandom, busy,
           ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b00,
           ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b00, "R4");
    end
    step(1, 0, 4'd2, 2'd0, 0, 0, 0, 0, "R5");
    step(1, 0, 4'd10, 2'd0, 0, 0, 0, 0, "R5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule